// File: doc/BRIEF.md
# SD Host Interrupt Status and Enable Unit

This unit gathers the event and error pulses raised elsewhere in an SD host controller into one 32-bit sticky status word. Software reads the word, acknowledges events by writing ones to the bits it has handled, and picks the events that matter through two separate masks. The first mask, the latch enable, decides whether an event is captured at all. The second mask, the line enable, decides which captured bits can raise the single interrupt line toward the processor.

A read-only present-status word sits next to the sticky word. It shows the controller's live command-inhibit, data-inhibit and data-active flags. These flags are never latched and cannot be changed by software. Bit 15 of the status word is a read-only summary that is set while any error bit is held. Access goes through a plain valid/write/address/data register port. Read data is combinational from the address. Writes take effect at the clock edge where valid and write are both high.

Top module: `sdhc_irq_status`

## Requirements
- R1: After synchronous reset, the status word, the latch-enable word and the line-enable word all read 0, and `irq_out` is low.
- R2: An event pulse on `ev_in[i]` whose latch-enable bit is 1 sets status bit i from the next cycle on. The bit stays set until it is cleared by a write, even if the enable is later removed. The implemented event bits are 0 (command done), 1 (data done), 3 (DMA), 4 (write ready), 5 (read ready), 6 (card insert) and 8 (card interrupt). The implemented error bits are 16 (command timeout), 17 (command CRC), 18 (command end bit), 19 (command index), 20 (data timeout), 21 (data CRC), 22 (data end bit), 24 (auto-command) and 28 (descriptor DMA).
- R3: An event whose latch-enable bit is 0 is never captured.
- R4: A write to the status word (offset 0x30) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R5: If a clearing write and a captured event hit the same bit in the same cycle, the bit stays set.
- R6: Status bit 15 reads as the OR of status bits 16 to 28. Writing it has no effect.
- R7: Reserved bits of the status word and of both enable words read as 0 and ignore writes. Events on reserved positions are never captured. Addresses with no register read 0.
- R8: `irq_out` is high exactly when some status bit (bit 15 included) is set and has its line-enable bit set. The line enable has no influence on capture.
- R9: The present-status word (offset 0x24) shows the command-inhibit input in bit 0, data-inhibit in bit 1 and data-active in bit 2. It follows the inputs in the same cycle, and writes to it have no effect.
- R10: The latch-enable word (offset 0x34) and the line-enable word (offset 0x38) read back the last value written to their implemented bits. The line-enable word also keeps bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ev_in | input | 32 | One-cycle event pulses, one per status bit position |
| cmd_inhibit | input | 1 | Live command-inhibit flag |
| dat_inhibit | input | 1 | Live data-inhibit flag |
| dat_active | input | 1 | Live data-active flag |
| irq_out | output | 1 | Interrupt request line |

## Verification
The bench aims at the cycle where an acknowledge write and a fresh event land on the same bit. A design that lets the clear win would drop that event for good. It also removes a latch enable after a bit has been captured: a design that gates the stored bit instead of the capture would lose the pending event. Writes of ones to bit 15, to reserved positions and to the present-status word are checked through readback, because a wrong design would keep phantom bits there. The interrupt line is checked with the line enable covering only the summary bit, so a design that leaves bit 15 out of the line OR stays silent on errors.

// File: rtl/sdhc_irq_pkg.sv
package sdhc_irq_pkg;

  localparam int unsigned WORD_W = 32;

  // bit positions of the sticky status word
  localparam int unsigned B_CMD_DONE  = 0;
  localparam int unsigned B_DAT_DONE  = 1;
  localparam int unsigned B_DMA       = 3;
  localparam int unsigned B_WR_RDY    = 4;
  localparam int unsigned B_RD_RDY    = 5;
  localparam int unsigned B_INSERT    = 6;
  localparam int unsigned B_CARD_IRQ  = 8;
  localparam int unsigned B_SUMMARY   = 15;
  localparam int unsigned B_CMD_TMO   = 16;
  localparam int unsigned B_CMD_CRC   = 17;
  localparam int unsigned B_CMD_END   = 18;
  localparam int unsigned B_CMD_IDX   = 19;
  localparam int unsigned B_DAT_TMO   = 20;
  localparam int unsigned B_DAT_CRC   = 21;
  localparam int unsigned B_DAT_END   = 22;
  localparam int unsigned B_AUTO_CMD  = 24;
  localparam int unsigned B_DESC_DMA  = 28;

  localparam logic [WORD_W-1:0] EVT_MASK =
      (32'd1 << B_CMD_DONE) | (32'd1 << B_DAT_DONE) | (32'd1 << B_DMA)
    | (32'd1 << B_WR_RDY)   | (32'd1 << B_RD_RDY)   | (32'd1 << B_INSERT)
    | (32'd1 << B_CARD_IRQ);

  localparam logic [WORD_W-1:0] ERR_MASK =
      (32'd1 << B_CMD_TMO) | (32'd1 << B_CMD_CRC) | (32'd1 << B_CMD_END)
    | (32'd1 << B_CMD_IDX) | (32'd1 << B_DAT_TMO) | (32'd1 << B_DAT_CRC)
    | (32'd1 << B_DAT_END) | (32'd1 << B_AUTO_CMD) | (32'd1 << B_DESC_DMA);

  // bits that hold a latch flop
  localparam logic [WORD_W-1:0] LATCH_MASK = EVT_MASK | ERR_MASK;
  // bits that are visible in the status readback
  localparam logic [WORD_W-1:0] VIEW_MASK  = LATCH_MASK | (32'd1 << B_SUMMARY);

  // present-status field positions
  localparam int unsigned P_CMD_INH = 0;
  localparam int unsigned P_DAT_INH = 1;
  localparam int unsigned P_DAT_ACT = 2;

  function automatic logic err_summary(input logic [WORD_W-1:0] stat);
    return |(stat & ERR_MASK);
  endfunction

  function automatic logic [WORD_W-1:0] status_view(input logic [WORD_W-1:0] stat);
    logic [WORD_W-1:0] v;
    v = stat & LATCH_MASK;
    v[B_SUMMARY] = err_summary(stat);
    return v;
  endfunction

  function automatic logic any_pending(input logic [WORD_W-1:0] view,
                                       input logic [WORD_W-1:0] line_en);
    return |(view & line_en);
  endfunction

  function automatic logic [WORD_W-1:0] next_status(input logic [WORD_W-1:0] stat,
                                                    input logic [WORD_W-1:0] set_bits,
                                                    input logic [WORD_W-1:0] clr_bits);
    return ((stat & ~clr_bits) | set_bits) & LATCH_MASK;
  endfunction

endpackage

// File: rtl/sdhc_irq_latch.sv
module sdhc_irq_latch
  import sdhc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] ev_in,
  input  logic [WORD_W-1:0] cap_en,
  input  logic [WORD_W-1:0] clr_req,
  output logic [WORD_W-1:0] stat_q
);

  logic [WORD_W-1:0] set_w;
  logic [WORD_W-1:0] clr_w;
  logic [WORD_W-1:0] blocked_w;
  logic [WORD_W-1:0] stat_d;

  assign set_w     = ev_in & cap_en & LATCH_MASK;
  assign clr_w     = clr_req & LATCH_MASK;
  assign blocked_w = ev_in & ~cap_en & ~stat_q;
  assign stat_d    = next_status(stat_q, set_w, clr_w);

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_d;
  end

  AST_HELD_BITS_STAY: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & ~clr_w) != '0) |=> ((stat_q & $past(stat_q & ~clr_w)) == $past(stat_q & ~clr_w))); // R2

  AST_MASKED_NOT_CAPTURED: assert property (@(posedge clk) disable iff (rst)
    (blocked_w != '0) |=> ((stat_q & $past(blocked_w)) == '0)); // R3

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
    ((clr_w & ~set_w) != '0) |=> ((stat_q & $past(clr_w & ~set_w)) == '0)); // R4

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ((set_w & clr_w) != '0) |=> ((stat_q & $past(set_w & clr_w)) == $past(set_w & clr_w))); // R5

endmodule

// File: rtl/sdhc_irq_enables.sv
module sdhc_irq_enables
  import sdhc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_cap,
  input  logic              wr_line,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] cap_en_q,
  output logic [WORD_W-1:0] line_en_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_en_q  <= '0;
      line_en_q <= '0;
    end else begin
      if (wr_cap)  cap_en_q  <= wdata & LATCH_MASK;
      if (wr_line) line_en_q <= wdata & VIEW_MASK;
    end
  end

  AST_EN_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
    wr_cap |=> (cap_en_q == ($past(wdata) & LATCH_MASK))); // R10

endmodule

// File: rtl/sdhc_irq_line.sv
module sdhc_irq_line
  import sdhc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] view,
  input  logic [WORD_W-1:0] line_en,
  output logic              irq_out
);

  assign irq_out = any_pending(view, line_en);

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (line_en != '0)); // R8

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (view != '0)); // R8

endmodule

// File: rtl/sdhc_irq_status.sv
module sdhc_irq_status
  import sdhc_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned OFS_PRES = 'h24,
  parameter int unsigned OFS_STAT = 'h30,
  parameter int unsigned OFS_CAP  = 'h34,
  parameter int unsigned OFS_LINE = 'h38
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       ev_in,
  input  logic              cmd_inhibit,
  input  logic              dat_inhibit,
  input  logic              dat_active,
  output logic              irq_out
);

  localparam logic [ADDR_W-1:0] A_PRES = ADDR_W'(OFS_PRES);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_CAP  = ADDR_W'(OFS_CAP);
  localparam logic [ADDR_W-1:0] A_LINE = ADDR_W'(OFS_LINE);

  logic              wr_hit;
  logic              wr_stat;
  logic              wr_cap;
  logic              wr_line;
  logic [WORD_W-1:0] clr_req;
  logic [WORD_W-1:0] stat_q;
  logic [WORD_W-1:0] cap_en_q;
  logic [WORD_W-1:0] line_en_q;
  logic [WORD_W-1:0] view_w;
  logic [WORD_W-1:0] pres_w;

  assign wr_hit  = bus_valid & bus_write;
  assign wr_stat = wr_hit && (bus_addr == A_STAT);
  assign wr_cap  = wr_hit && (bus_addr == A_CAP);
  assign wr_line = wr_hit && (bus_addr == A_LINE);
  assign clr_req = wr_stat ? bus_wdata : '0;

  sdhc_irq_latch u_latch (
    .clk    (clk),
    .rst    (rst),
    .ev_in  (ev_in),
    .cap_en (cap_en_q),
    .clr_req(clr_req),
    .stat_q (stat_q)
  );

  sdhc_irq_enables u_enables (
    .clk      (clk),
    .rst      (rst),
    .wr_cap   (wr_cap),
    .wr_line  (wr_line),
    .wdata    (bus_wdata),
    .cap_en_q (cap_en_q),
    .line_en_q(line_en_q)
  );

  assign view_w = status_view(stat_q);

  sdhc_irq_line u_line (
    .clk    (clk),
    .rst    (rst),
    .view   (view_w),
    .line_en(line_en_q),
    .irq_out(irq_out)
  );

  always_comb begin
    pres_w            = '0;
    pres_w[P_CMD_INH] = cmd_inhibit;
    pres_w[P_DAT_INH] = dat_inhibit;
    pres_w[P_DAT_ACT] = dat_active;
  end

  always_comb begin
    unique case (bus_addr)
      A_PRES:  bus_rdata = pres_w;
      A_STAT:  bus_rdata = view_w;
      A_CAP:   bus_rdata = cap_en_q;
      A_LINE:  bus_rdata = line_en_q;
      default: bus_rdata = '0;
    endcase
  end

  AST_SUMMARY_FOLLOWS_ERRORS: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == A_STAT) |-> (bus_rdata[B_SUMMARY] == (|(bus_rdata & ERR_MASK)))); // R6

  AST_RESERVED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == A_STAT) |-> ((bus_rdata & ~VIEW_MASK) == '0)); // R7

  AST_CLEARED_STATE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (line_en_q == '0) |-> !irq_out); // R8

endmodule

// File: tb/test_sdhc_irq_status.sv
module test_sdhc_irq_status;

  localparam logic [31:0] M_LATCH = 32'h117F_017B;
  localparam logic [31:0] M_ERR   = 32'h117F_0000;
  localparam logic [31:0] M_LINE  = 32'h117F_817B;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = 8'h30;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] ev_in = '0;
  logic        cmd_inhibit = 1'b0;
  logic        dat_inhibit = 1'b0;
  logic        dat_active = 1'b0;
  logic        irq_out;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [31:0] m_stat = '0;
  logic [31:0] m_cap  = '0;
  logic [31:0] m_line = '0;

  always #2 clk = ~clk;

  sdhc_irq_status i_sdhc_irq_status (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_in(ev_in), .cmd_inhibit(cmd_inhibit), .dat_inhibit(dat_inhibit),
    .dat_active(dat_active), .irq_out(irq_out)
  );

  function automatic logic [31:0] m_view();
    logic [31:0] v;
    v = m_stat;
    if ((m_stat & M_ERR) != 0) v = v | 32'h0000_8000;
    return v;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h24:   return {29'd0, dat_active, dat_inhibit, cmd_inhibit};
      8'h30:   return m_view();
      8'h34:   return m_cap;
      8'h38:   return m_line;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_stat <= '0; m_cap <= '0; m_line <= '0;
    end else begin
      logic [31:0] clr;
      logic [31:0] setb;
      clr  = (bus_valid && bus_write && bus_addr == 8'h30) ? bus_wdata : 32'd0;
      setb = ev_in & m_cap & M_LATCH;
      m_stat <= ((m_stat & ~clr) | setb) & M_LATCH;
      if (bus_valid && bus_write && bus_addr == 8'h34) m_cap  <= bus_wdata & M_LATCH;
      if (bus_valid && bus_write && bus_addr == 8'h38) m_line <= bus_wdata & M_LINE;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst) begin
      chk(bus_addr == 8'h24 ? "R9" : (bus_addr == 8'h30 ? "R2" :
          ((bus_addr == 8'h34 || bus_addr == 8'h38) ? "R10" : "R7")),
          bus_rdata, m_read(bus_addr));
      chk("R8", {31'd0, irq_out}, {31'd0, ((m_view() & m_line) != 0)});
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [31:0] ev);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; ev_in = ev;
    step();
    bus_valid = 1'b0; bus_write = 1'b0; ev_in = '0;
  endtask

  task automatic pulse(input logic [31:0] ev);
    ev_in = ev;
    step();
    ev_in = '0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    step();
    chk(req, bus_rdata, exp);
  endtask

  task automatic irq_is(input string req, input logic exp);
    step();
    chk(req, {31'd0, irq_out}, {31'd0, exp});
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    // R1 reset values
    rd("R1", 8'h30, 32'h0);
    rd("R1", 8'h34, 32'h0);
    rd("R1", 8'h38, 32'h0);
    irq_is("R1", 1'b0);
    // R3 nothing captured with latch enable cleared
    pulse(32'hFFFF_FFFF);
    rd("R3", 8'h30, 32'h0);
    // R10 / R7 enable readback masks reserved bits
    wr(8'h34, 32'hFFFF_FFFF, 32'h0);
    rd("R10", 8'h34, M_LATCH);
    // R2 command done bit 0, R6 summary with descriptor error bit 28
    pulse(32'h0000_0001);
    rd("R2", 8'h30, 32'h0000_0001);
    pulse(32'h1000_0000);
    rd("R6", 8'h30, 32'h1000_8001);
    // R8 line stays low until enabled
    irq_is("R8", 1'b0);
    wr(8'h38, 32'h0000_0001, 32'h0);
    rd("R10", 8'h38, 32'h0000_0001);
    irq_is("R8", 1'b1);
    // R4 writing zeros keeps bits, R6 summary not writable
    wr(8'h30, 32'h0000_0000, 32'h0);
    rd("R4", 8'h30, 32'h1000_8001);
    wr(8'h30, 32'h0000_8000, 32'h0);
    rd("R6", 8'h30, 32'h1000_8001);
    wr(8'h30, 32'h0000_0001, 32'h0);
    rd("R4", 8'h30, 32'h1000_8000);
    irq_is("R8", 1'b0);
    // R8 summary bit drives the line
    wr(8'h38, 32'h0000_8000, 32'h0);
    irq_is("R8", 1'b1);
    // R5 clear and event on the same bit in the same cycle
    wr(8'h30, 32'h1000_0000, 32'h1000_0000);
    rd("R5", 8'h30, 32'h1000_8000);
    wr(8'h30, 32'h1000_0000, 32'h0);
    rd("R4", 8'h30, 32'h0);
    irq_is("R8", 1'b0);
    // R7 reserved event positions and reserved write bits
    pulse(32'h0000_0004 | 32'h2000_0000 | 32'h0080_0000);
    rd("R7", 8'h30, 32'h0);
    wr(8'h38, 32'hFFFF_FFFF, 32'h0);
    rd("R7", 8'h38, M_LINE);
    rd("R7", 8'h40, 32'h0);
    // R2 captured bit survives removal of its latch enable; R3 new event blocked
    pulse(32'h0000_0010);
    wr(8'h34, 32'h0, 32'h0);
    pulse(32'h0000_0020);
    rd("R2", 8'h30, 32'h0000_0010);
    irq_is("R8", 1'b1);
    wr(8'h30, 32'hFFFF_FFFF, 32'h0);
    rd("R4", 8'h30, 32'h0);
    // R9 live present-status flags, writes ignored
    cmd_inhibit = 1'b1; dat_active = 1'b1;
    rd("R9", 8'h24, 32'h0000_0005);
    wr(8'h24, 32'h0, 32'h0);
    rd("R9", 8'h24, 32'h0000_0005);
    dat_inhibit = 1'b1; cmd_inhibit = 1'b0;
    rd("R9", 8'h24, 32'h0000_0006);
    // mixed traffic compared cycle by cycle against the reference
    wr(8'h34, 32'h00F0_0123, 32'h0);
    for (int k = 0; k < 40; k++) begin
      ev_in = 32'h9E37_79B9 * (k + 1) ^ (32'h1 << (k % 32));
      bus_addr = (k % 3 == 0) ? 8'h30 : ((k % 3 == 1) ? 8'h34 : 8'h38);
      bus_valid = (k % 4 == 0); bus_write = 1'b1;
      bus_addr = bus_valid ? 8'h30 : bus_addr;
      bus_wdata = 32'h0F0F_0F0F << (k % 5);
      step();
    end
    bus_valid = 1'b0; ev_in = '0;
    step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule